// File: doc/BRIEF.md
# Bit Test-and-Modify Unit

This unit carries out single-bit operations on one operand. The operand is either a 32-bit register value supplied with the command or one byte in memory. Four bit operations are available: clear, set, invert and test. Each one captures the old value of the chosen bit into a flag output before anything is changed. Clear, set and invert then write the changed operand back. Test writes nothing.

A fifth command, convert, multiplies a byte address by eight and adds a signed bit offset. The result is a flat bit address. This command does not change the flag.

Register commands and convert finish one cycle after they are accepted. Memory commands use a handshake with one request outstanding at a time. They read the byte, and for clear, set and invert they write it back to the same address. The signed offset of a memory command may have any value. Its upper bits, shifted arithmetically right by three, move the access away from the base byte, and its three low bits choose the bit within that byte. Commands are taken only while the unit is idle.

Top module: `bit_rmw_unit`

## Requirements
- R1: After reset, busy, done, flag, reg_we, cvt_valid and mem_req are all 0.
- R2: Operation codes on cmd_op are 0 clear, 1 set, 2 invert, 3 test and 4 convert. With cmd_mem=0, the bit at index cmd_off[4:0] of cmd_reg_val is forced to 0 by clear, forced to 1 by set, or inverted by invert. The result appears on reg_wdata with reg_we=1, and flag shows the bit's old value.
- R3: A register test sets flag to the old bit value. It drives reg_we=0, and reg_wdata carries cmd_reg_val unchanged.
- R4: Register commands and convert raise done for exactly one cycle, in the cycle after the command is accepted. reg_we and cvt_valid are high only while done is high.
- R5: For memory commands, mem_addr = cmd_addr + (cmd_off arithmetic-shifted right by 3), and the bit index is cmd_off[2:0]. Once mem_req is raised, mem_req, mem_we and mem_addr stay steady until mem_ack.
- R6: Memory clear, set and invert perform one read and then one write to the same address. The written byte differs from the read byte only in the chosen bit, and flag takes the old bit value.
- R7: A memory test performs only the read. It updates flag and issues no write.
- R8: Convert drives cvt_addr = cmd_addr*8 + cmd_off (modulo 2^32), with cvt_valid=1 for one cycle.
- R9: busy is high from the cycle after acceptance through the cycle in which done is high. A cmd_valid that arrives while busy is ignored.
- R10: flag changes only when an old bit is captured. Convert and idle cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; taken when the unit is idle |
| cmd_op | input | 3 | Operation code |
| cmd_mem | input | 1 | 1 = memory operand, 0 = register operand |
| cmd_reg_val | input | 32 | Register operand value |
| cmd_addr | input | 32 | Byte base address |
| cmd_off | input | 32 | Signed bit offset |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| flag | output | 1 | Old value of the last bit captured |
| reg_we | output | 1 | Register write-back enable |
| reg_wdata | output | 32 | Updated register value |
| cvt_valid | output | 1 | Convert result valid |
| cvt_addr | output | 32 | Flat bit address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Request completed this cycle |

## Verification
The assertions assume three things about the inputs. cmd_op holds only codes 0 to 4. mem_ack is raised only while mem_req is high. Register commands keep cmd_off within 0 to 31. The bench's memory model acknowledges only requests that are pending, one cycle after they appear, and lowers mem_ack in the cycle after each acknowledge. Every command the bench issues uses a legal code and, for register operands, an offset within range. Negative memory offsets are used on purpose to exercise accesses below the base byte.

// File: rtl/bit_rmw_unit.sv
module bit_rmw_unit #(
  parameter int AW = 32,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_mem,
  input  logic [RW-1:0] cmd_reg_val,
  input  logic [AW-1:0] cmd_addr,
  input  logic [AW-1:0] cmd_off,
  output logic          busy,
  output logic          done,
  output logic          flag,
  output logic          reg_we,
  output logic [RW-1:0] reg_wdata,
  output logic          cvt_valid,
  output logic [AW-1:0] cvt_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ack
);
  localparam int BW = $clog2(RW);
  localparam logic [2:0] OP_CLR = 3'd0, OP_SET = 3'd1, OP_INV = 3'd2,
                         OP_TST = 3'd3, OP_CVT = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FIN} st_t;

  st_t            st;
  logic [2:0]     op_q;
  logic           mem_q;
  logic [AW-1:0]  res_q;
  logic [AW-1:0]  addr_q;
  logic [2:0]     bit_q;
  logic [7:0]     wbyte_q;
  logic           flag_q;

  function automatic logic new_bit(input logic [2:0] op, input logic old);
    case (op)
      OP_CLR:  return 1'b0;
      OP_SET:  return 1'b1;
      OP_INV:  return ~old;
      default: return old;
    endcase
  endfunction

  wire           accept = cmd_valid && (st == S_IDLE);
  wire [BW-1:0]  rbit   = cmd_off[BW-1:0];
  wire           rold   = cmd_reg_val[rbit];
  wire [AW-1:0]  disp   = AW'($signed(cmd_off) >>> 3);
  wire           mold   = mem_rdata[bit_q];

  logic [RW-1:0] rnew;
  logic [7:0]    mnew;
  always_comb begin
    rnew = cmd_reg_val;
    rnew[rbit] = new_bit(cmd_op, rold);
    mnew = mem_rdata;
    mnew[bit_q] = new_bit(op_q, mold);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_TST;
      mem_q   <= 1'b0;
      res_q   <= '0;
      addr_q  <= '0;
      bit_q   <= '0;
      wbyte_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q  <= cmd_op;
          mem_q <= cmd_mem;
          if (cmd_op == OP_CVT) begin
            res_q <= (cmd_addr << 3) + cmd_off;
            st    <= S_FIN;
          end else if (!cmd_mem) begin
            res_q  <= AW'(rnew);
            flag_q <= rold;
            st     <= S_FIN;
          end else begin
            addr_q <= cmd_addr + disp;
            bit_q  <= cmd_off[2:0];
            st     <= S_RD;
          end
        end
        S_RD: if (mem_ack) begin
          flag_q  <= mold;
          wbyte_q <= mnew;
          st      <= (op_q == OP_TST) ? S_FIN : S_WR;
        end
        S_WR: if (mem_ack) st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign flag      = flag_q;
  assign reg_we    = done && !mem_q && (op_q inside {OP_CLR, OP_SET, OP_INV});
  assign reg_wdata = RW'(res_q);
  assign cvt_valid = done && (op_q == OP_CVT);
  assign cvt_addr  = res_q;
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = wbyte_q;

  assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_test_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (op_q != OP_TST));
  assert_outputs_in_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || cvt_valid) |-> (done && $onehot0({reg_we, cvt_valid})));
  assert_flag_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !cmd_valid) |=> $stable(flag));
  assert_write_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !$past(mem_we)) |-> ($past(mem_req) && $past(mem_ack) && $stable(mem_addr)));
endmodule

// File: tb/bit_rmw_unit_tb_top.sv
module bit_rmw_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_valid = 0, cmd_mem = 0;
  logic [2:0]  cmd_op = 0;
  logic [31:0] cmd_reg_val = 0, cmd_addr = 0, cmd_off = 0;
  logic        busy, done, flag, reg_we, cvt_valid, mem_req, mem_we;
  logic [31:0] reg_wdata, cvt_addr, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ack;

  bit_rmw_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_mem(cmd_mem),
    .cmd_reg_val(cmd_reg_val), .cmd_addr(cmd_addr), .cmd_off(cmd_off),
    .busy(busy), .done(done), .flag(flag), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .cvt_valid(cvt_valid), .cvt_addr(cvt_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  logic [7:0] mem [256];
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd_addr = 0, last_wr_addr = 0;
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) begin
          mem[mem_addr[7:0]] <= mem_wdata;
          wr_cnt <= wr_cnt + 1;
          last_wr_addr <= mem_addr;
        end else begin
          rd_cnt <= rd_cnt + 1;
          last_rd_addr <= mem_addr;
        end
      end
    end
  end

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic issue(input logic [2:0] op, input logic m, input logic [31:0] rv,
                       input logic [31:0] a, input logic [31:0] o);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_mem = m; cmd_reg_val = rv; cmd_addr = a; cmd_off = o;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 50 && !done; n++) @(negedge clk);
  endtask

  // {op, value, offset, expected value, expected flag, expected we}
  localparam logic [76:0] VEC [6] = '{
    {3'd1, 32'h0000_0000, 8'd5,  32'h0000_0020, 1'b0, 1'b1},
    {3'd0, 32'hFFFF_FFFF, 8'd31, 32'h7FFF_FFFF, 1'b1, 1'b1},
    {3'd2, 32'h1234_5678, 8'd3,  32'h1234_5670, 1'b1, 1'b1},
    {3'd3, 32'h8000_0001, 8'd0,  32'h8000_0001, 1'b1, 1'b0},
    {3'd1, 32'hFFFF_FFFF, 8'd16, 32'hFFFF_FFFF, 1'b1, 1'b1},
    {3'd2, 32'h0000_0000, 8'd31, 32'h8000_0000, 1'b0, 1'b1}
  };

  int w0;
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h3F] = 8'hFF; mem[8'h3E] = 8'h80; mem[8'h45] = 8'h04;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !flag && !reg_we && !cvt_valid && !mem_req, "R1 reset",
        {26'b0, busy, done, flag, reg_we, cvt_valid, mem_req}, 32'h0);
    rst_n = 1;

    foreach (VEC[k]) begin
      issue(VEC[k][76:74], 1'b0, VEC[k][73:42], 32'h0, {24'h0, VEC[k][41:34]});
      chk(done && busy, "R4 done one cycle after accept", {30'b0, done, busy}, 32'h3);
      chk(reg_we == VEC[k][0], "R2/R3 reg_we", {31'b0, reg_we}, {31'b0, VEC[k][0]});
      chk(reg_wdata == VEC[k][33:2], "R2/R3 reg_wdata", reg_wdata, VEC[k][33:2]);
      chk(flag == VEC[k][1], "R2/R3 flag", {31'b0, flag}, {31'b0, VEC[k][1]});
      @(negedge clk);
      chk(!done && !busy && !reg_we, "R9 R4 single pulse", {29'b0, done, busy, reg_we}, 32'h0);
    end

    // R6 memory set, offset 13 from 0x40 -> byte 0x41 bit 5
    issue(3'd1, 1'b1, 32'h0, 32'h40, 32'd13);
    wait_done();
    chk(mem[8'h41] == 8'h20, "R6 mem set byte", {24'b0, mem[8'h41]}, 32'h20);
    chk(flag == 1'b0, "R6 mem set flag", {31'b0, flag}, 32'h0);
    chk(last_rd_addr == 32'h41 && last_wr_addr == 32'h41, "R5 address", last_wr_addr, 32'h41);

    // R5 negative offset -1 -> byte 0x3F bit 7, invert
    issue(3'd2, 1'b1, 32'h0, 32'h40, 32'hFFFF_FFFF);
    wait_done();
    chk(last_wr_addr == 32'h3F, "R5 negative offset address", last_wr_addr, 32'h3F);
    chk(mem[8'h3F] == 8'h7F && flag, "R6 mem invert", {23'b0, flag, mem[8'h3F]}, 32'h17F);

    // offset -9 -> byte 0x3E bit 7, clear
    issue(3'd0, 1'b1, 32'h0, 32'h40, 32'hFFFF_FFF7);
    wait_done();
    chk(last_wr_addr == 32'h3E, "R5 offset -9 address", last_wr_addr, 32'h3E);
    chk(mem[8'h3E] == 8'h00 && flag, "R6 mem clear", {23'b0, flag, mem[8'h3E]}, 32'h100);

    // R7 memory test: byte 0x45 bit 2, no write
    w0 = wr_cnt;
    issue(3'd3, 1'b1, 32'h0, 32'h44, 32'd10);
    wait_done();
    chk(flag == 1'b1, "R7 mem test flag", {31'b0, flag}, 32'h1);
    @(negedge clk);
    chk(wr_cnt == w0, "R7 mem test no write", wr_cnt, w0);
    chk(last_rd_addr == 32'h45 && mem[8'h45] == 8'h04, "R7 read address and byte", last_rd_addr, 32'h45);

    // R8 convert, R10 flag kept
    issue(3'd4, 1'b0, 32'h0, 32'h100, 32'd5);
    chk(cvt_valid && cvt_addr == 32'h805, "R8 convert positive", cvt_addr, 32'h805);
    chk(!reg_we, "R4 no reg_we on convert", {31'b0, reg_we}, 32'h0);
    issue(3'd4, 1'b1, 32'h0, 32'h100, 32'hFFFF_FFFD);
    chk(cvt_valid && cvt_addr == 32'h7FD, "R8 convert negative", cvt_addr, 32'h7FD);
    chk(flag == 1'b1, "R10 flag kept after convert", {31'b0, flag}, 32'h1);

    // R9 command while busy is ignored
    w0 = wr_cnt;
    issue(3'd1, 1'b1, 32'h0, 32'h50, 32'd0);
    chk(busy, "R9 busy after accept", {31'b0, busy}, 32'h1);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'd1; cmd_mem = 1; cmd_addr = 32'h80; cmd_off = 32'd0;
    @(negedge clk);
    cmd_valid = 0;
    wait_done();
    chk(busy, "R9 busy during done", {31'b0, busy}, 32'h1);
    repeat (8) @(negedge clk);
    chk(mem[8'h50] == 8'h01, "R9 first command done", {24'b0, mem[8'h50]}, 32'h1);
    chk(mem[8'h80] == 8'h00 && wr_cnt == w0 + 1, "R9 busy command ignored", wr_cnt, w0 + 1);
    chk(!busy, "R9 idle after done", {31'b0, busy}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule